// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block is one input port of a network-on-chip router. A single flit link (valid/ready) feeds several virtual-channel FIFOs. When a packet opens, the port reads the fill level of every virtual channel and steers the packet into the emptiest one. That channel then takes every flit of the packet until the tail flit has been written. This way, interleaved traffic cannot block a channel that is shared with another packet.

On the output side, a round-robin selector picks one flit per cycle from the non-empty channels. It presents the flit to the switch together with the channel index and the output-port request that the external route logic supplies for that channel. Per-channel fill counts are exported so that neighbouring logic can watch for congestion. The channel count, the channel depth, the flit width and the route-request width are all compile-time parameters.

Top module: `vc_input_port`

## Requirements
- R1: After reset every channel is empty, `occupancy_o` is all zero, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: A flit that arrives while no packet is open is steered to the channel with the smallest count. When two or more channels have the same count, the one with the lower index is taken.
- R3: After a non-tail flit opens a packet, each later accepted flit goes to the same channel. The packet closes when its tail flit is written.
- R4: `in_ready_o` is 0 exactly when the channel that the current flit would be written to holds DEPTH flits. That channel is the locked channel while a packet is open, and the emptiest channel otherwise.
- R5: `out_valid_o` is 1 when any channel is non-empty. `out_vc_o` is then the first non-empty channel found by counting upward, with wrap-around, from the round-robin pointer. After reset the pointer is 0. It moves to the channel after the one served only on a cycle where a flit leaves (`out_valid_o && out_ready_i`).
- R6: `out_port_o` equals the slice `route_req_i[out_vc_o*PORT_W +: PORT_W]`.
- R7: Field v of `occupancy_o` (bits `v*CNT_W +: CNT_W`) holds the number of flits stored in channel v. That number never exceeds DEPTH.
- R8: Each channel returns its flits on `out_flit_o` in the order they were written, with no change to their bits.
- R9: The flit type sits in the two most significant bits of the flit: 00 is header, 01 is data, 10 is address and 11 is tail. Only type 11 closes a packet. Data and address flits stay on the locked channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming flit is valid |
| in_ready_o | output | 1 | Port can accept the incoming flit |
| in_flit_i | input | FLIT_W | Incoming flit, type in the top two bits |
| route_req_i | input | NUM_VC*PORT_W | Output-port request for the head flit of each channel |
| out_valid_o | output | 1 | A flit is offered to the switch |
| out_ready_i | input | 1 | Switch takes the offered flit |
| out_flit_o | output | FLIT_W | Offered flit |
| out_vc_o | output | IDX_W | Channel that the offered flit comes from |
| out_port_o | output | PORT_W | Output-port request for the offered flit |
| occupancy_o | output | NUM_VC*CNT_W | Per-channel fill counts |

## Verification
The assertions assume that the upstream sender keeps its packets well formed. Each packet begins with a header, closes with a tail, and is never interleaved with another packet on the same link. They also assume that the only writes are the ones that `in_ready_o` allows. The stimulus builds packets of two to six flits from a generator that emits a tail only as the last flit of a packet, and it holds each flit until that flit is accepted. Valid and ready are then switched randomly in phases of light, medium and full drain rate, so that both the locked-channel and the new-header full conditions come up.

// File: rtl/vcip_pkg.sv
`timescale 1ns/1ps
package vcip_pkg;
  typedef enum logic [1:0] {
    FLIT_HEAD = 2'b00,
    FLIT_DATA = 2'b01,
    FLIT_ADDR = 2'b10,
    FLIT_TAIL = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/vcip_fifo.sv
`timescale 1ns/1ps
module vcip_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= step(wr_q);
      if (pop_i)  rd_q <= step(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/vcip_least_sel.sv
`timescale 1ns/1ps
module vcip_least_sel #(
  parameter int NUM_VC = 4,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_VC*CNT_W-1:0] counts_i,
  output logic [IDX_W-1:0]        idx_o
);
  logic [CNT_W-1:0] best_cnt;

  // strict compare keeps the lowest index on ties
  always_comb begin
    idx_o    = '0;
    best_cnt = counts_i[0 +: CNT_W];
    for (int i = 1; i < NUM_VC; i++) begin
      if (counts_i[i*CNT_W +: CNT_W] < best_cnt) begin
        idx_o    = IDX_W'(i);
        best_cnt = counts_i[i*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/vcip_rr_arb.sv
`timescale 1ns/1ps
module vcip_rr_arb #(
  parameter int NUM_VC = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_VC-1:0] req_i,
  input  logic              take_i,
  output logic [IDX_W-1:0]  gnt_o,
  output logic              gnt_valid_o,
  output logic [IDX_W-1:0]  ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  // scan downward so the smallest offset from the pointer is written last
  always_comb begin
    int idx;
    gnt_o       = '0;
    gnt_valid_o = |req_i;
    for (int i = NUM_VC - 1; i >= 0; i--) begin
      idx = int'(ptr_q) + i;
      if (idx >= NUM_VC) idx = idx - NUM_VC;
      if (req_i[idx]) gnt_o = IDX_W'(idx);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (take_i) begin
      ptr_q <= (gnt_o == IDX_W'(NUM_VC - 1)) ? '0 : gnt_o + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/vc_input_port.sv
`timescale 1ns/1ps
module vc_input_port #(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 4,
  parameter int FLIT_W = 18,
  parameter int PORT_W = 3,
  parameter int IDX_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [FLIT_W-1:0]       in_flit_i,
  input  logic [NUM_VC*PORT_W-1:0] route_req_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [FLIT_W-1:0]       out_flit_o,
  output logic [IDX_W-1:0]        out_vc_o,
  output logic [PORT_W-1:0]       out_port_o,
  output logic [NUM_VC*CNT_W-1:0] occupancy_o
);
  import vcip_pkg::*;

  logic [NUM_VC-1:0]       push, pop, full, empty;
  logic [FLIT_W-1:0]       head [NUM_VC];
  logic [NUM_VC*CNT_W-1:0] counts;
  logic [IDX_W-1:0]        least_idx, target, gnt, rr_ptr;
  logic                    gnt_valid, accept, take;
  logic                    locked_q;
  logic [IDX_W-1:0]        lock_vc_q;
  flit_kind_e              kind;

  assign kind = flit_kind_e'(in_flit_i[FLIT_W-1 -: 2]);

  vcip_least_sel #(.NUM_VC(NUM_VC), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_least (
    .counts_i (counts),
    .idx_o    (least_idx)
  );

  assign target     = locked_q ? lock_vc_q : least_idx;
  assign in_ready_o = !full[target];
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q  <= 1'b0;
      lock_vc_q <= '0;
    end else if (accept) begin
      if (kind == FLIT_TAIL) begin
        locked_q <= 1'b0;
      end else begin
        locked_q  <= 1'b1;
        lock_vc_q <= target;
      end
    end
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    assign push[v] = accept && (target == IDX_W'(v));
    assign pop[v]  = take && (gnt == IDX_W'(v));

    vcip_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[v]),
      .data_i  (in_flit_i),
      .pop_i   (pop[v]),
      .data_o  (head[v]),
      .count_o (counts[v*CNT_W +: CNT_W]),
      .full_o  (full[v]),
      .empty_o (empty[v])
    );
  end

  vcip_rr_arb #(.NUM_VC(NUM_VC), .IDX_W(IDX_W)) i_rr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (~empty),
    .take_i      (take),
    .gnt_o       (gnt),
    .gnt_valid_o (gnt_valid),
    .ptr_o       (rr_ptr)
  );

  assign take        = gnt_valid && out_ready_i;
  assign out_valid_o = gnt_valid;
  assign out_vc_o    = gnt;
  assign out_flit_o  = head[gnt];
  assign out_port_o  = route_req_i[gnt*PORT_W +: PORT_W];
  assign occupancy_o = counts;
endmodule

// File: rtl/vcip_checker.sv
`timescale 1ns/1ps
module vcip_checker #(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 4,
  parameter int FLIT_W = 18,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    in_ready_o,
  input logic [FLIT_W-1:0]       in_flit_i,
  input logic                    out_valid_o,
  input logic                    out_ready_i,
  input logic [IDX_W-1:0]        out_vc_o,
  input logic [NUM_VC*CNT_W-1:0] occupancy_o,
  input logic                    locked_i,
  input logic [IDX_W-1:0]        lock_vc_i,
  input logic [IDX_W-1:0]        rr_ptr_i
);
  logic [CNT_W-1:0] occ [NUM_VC];
  int               total;
  logic             acc, popd, is_tail, armed_q;
  logic [IDX_W-1:0] nxt_ptr;

  always_comb begin
    total = 0;
    for (int i = 0; i < NUM_VC; i++) begin
      occ[i] = occupancy_o[i*CNT_W +: CNT_W];
      total  = total + int'(occ[i]);
    end
  end

  assign acc     = in_valid_i && in_ready_o;
  assign popd    = out_valid_o && out_ready_i;
  assign is_tail = (in_flit_i[FLIT_W-1 -: 2] == 2'b11);
  assign nxt_ptr = (out_vc_o == IDX_W'(NUM_VC - 1)) ? '0 : out_vc_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_bound
    // R7
    occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ[v] <= CNT_W'(DEPTH));
  end

  // R7
  occ_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    total == $past(total) + int'($past(acc)) - int'($past(popd)));

  // R5
  gnt_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> occ[out_vc_o] != '0);

  // R5
  idle_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> total == 0);

  // R5
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    popd |=> rr_ptr_i == $past(nxt_ptr));

  // R4
  lock_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && occ[lock_vc_i] == CNT_W'(DEPTH)) |-> !in_ready_o);

  // R3
  lock_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && acc && !is_tail) |=> (locked_i && lock_vc_i == $past(lock_vc_i)));
endmodule

bind vc_input_port vcip_checker #(
  .NUM_VC(NUM_VC), .DEPTH(DEPTH), .FLIT_W(FLIT_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) i_vcip_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_flit_i   (in_flit_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_vc_o    (out_vc_o),
  .occupancy_o (occupancy_o),
  .locked_i    (locked_q),
  .lock_vc_i   (lock_vc_q),
  .rr_ptr_i    (rr_ptr)
);

// File: tb/test_vc_input_port.sv
`timescale 1ns/1ps
module test_vc_input_port;
  localparam int NV = 4, DEPTH = 4, FW = 18, PW = 3, IW = 2, CW = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic             in_valid, in_ready, out_valid, out_ready;
  logic [FW-1:0]    in_flit, out_flit;
  logic [NV*PW-1:0] route;
  logic [IW-1:0]    out_vc;
  logic [PW-1:0]    out_port;
  logic [NV*CW-1:0] occ;

  vc_input_port #(.NUM_VC(NV), .DEPTH(DEPTH), .FLIT_W(FW), .PORT_W(PW)) i_vc_input_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_flit_i   (in_flit),
    .route_req_i (route),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_flit_o  (out_flit),
    .out_vc_o    (out_vc),
    .out_port_o  (out_port),
    .occupancy_o (occ)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [FW-1:0] mq [NV][$];
  int  ptr_m = 0, lvc_m = 0;
  bit  lock_m = 0;

  int  pkt_left = 0;
  bit  have = 0;
  logic [FW-1:0] cur;
  logic [15:0]   pay = 16'h100;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [1:0] k, input logic [15:0] p);
    return {k, p};
  endfunction

  function automatic int occ_of(input int v);
    return int'(occ[v*CW +: CW]);
  endfunction

  // one clock: drive, compare against the reference queues, then advance them
  task automatic cycle(input bit v, input logic [FW-1:0] f, input bit r, output bit acc);
    int least, tgt, gnt;
    bit ev, er;
    @(negedge clk_i);
    in_valid  = v;
    in_flit   = f;
    out_ready = r;
    route     = NV*PW'($urandom);
    #1;
    least = 0;
    for (int i = 1; i < NV; i++) if (mq[i].size() < mq[least].size()) least = i;
    tgt = lock_m ? lvc_m : least;
    er  = mq[tgt].size() < DEPTH;
    gnt = -1;
    for (int i = NV - 1; i >= 0; i--) begin
      int x = (ptr_m + i) % NV;
      if (mq[x].size() != 0) gnt = x;
    end
    ev = (gnt >= 0);
    chk(in_ready == er, "R4", "in_ready", in_ready, er);
    for (int i = 0; i < NV; i++)
      chk(occ_of(i) == mq[i].size(), "R7", "occupancy", occ_of(i), mq[i].size());
    chk(out_valid == ev, "R5", "out_valid", out_valid, ev);
    if (ev) begin
      chk(int'(out_vc) == gnt, "R5", "out_vc", out_vc, gnt);
      chk(out_flit == mq[gnt][0], "R8", "out_flit", out_flit, mq[gnt][0]);
      chk(out_port == route[gnt*PW +: PW], "R6", "out_port", out_port, route[gnt*PW +: PW]);
    end
    acc = v && er;
    @(posedge clk_i);
    if (acc) begin
      mq[tgt].push_back(f);
      if (f[FW-1 -: 2] == 2'b11) lock_m = 0;
      else begin lock_m = 1; lvc_m = tgt; end
    end
    if (ev && r) begin
      void'(mq[gnt].pop_front());
      ptr_m = (gnt + 1) % NV;
    end
  endtask

  task automatic gen_flit();
    logic [1:0] k;
    if (!have) begin
      if (pkt_left == 0) begin
        pkt_left = 2 + int'($urandom % 5);
        k = 2'b00;
      end else if (pkt_left == 1) k = 2'b11;
      else k = ($urandom % 2) ? 2'b01 : 2'b10;
      cur  = mk(k, pay);
      pay  = pay + 1'b1;
      have = 1;
    end
  endtask

  initial begin
    bit a;
    in_valid = 0; in_flit = '0; out_ready = 0; route = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(occ == '0, "R1", "reset occupancy", occ, 0);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    rst_ni = 1'b1;

    // packet A: header, address, data, tail -> channel 0 (R9 type codes)
    cycle(1, mk(2'b00, 16'h0a0), 0, a);
    cycle(1, mk(2'b10, 16'h0a1), 0, a);
    cycle(1, mk(2'b01, 16'h0a2), 0, a);
    cycle(1, mk(2'b11, 16'h0a3), 0, a);
    #2;
    chk(occ_of(0) == 4, "R3", "packet A kept on vc0", occ_of(0), 4);
    chk(occ_of(1) == 0, "R9", "address/data did not close packet", occ_of(1), 0);

    // packet B: ties among 1..3 -> lowest index 1
    cycle(1, mk(2'b00, 16'h0b0), 0, a);
    #2;
    chk(occ_of(1) == 1, "R2", "header to emptiest, lowest index", occ_of(1), 1);
    cycle(1, mk(2'b11, 16'h0b1), 0, a);

    // packet C: 1 holds 2, so 2 wins over 3 on tie
    cycle(1, mk(2'b00, 16'h0c0), 0, a);
    #2;
    chk(occ_of(2) == 1, "R2", "header to vc2", occ_of(2), 1);
    cycle(1, mk(2'b01, 16'h0c1), 0, a);
    cycle(1, mk(2'b01, 16'h0c2), 0, a);
    cycle(1, mk(2'b01, 16'h0c3), 0, a);
    cycle(1, mk(2'b01, 16'h0c4), 0, a);
    #2;
    chk(in_ready == 1'b0, "R4", "locked vc full stalls link", in_ready, 0);
    chk(occ_of(3) == 0, "R3", "stalled flit not redirected", occ_of(3), 0);
    have = 1; cur = mk(2'b01, 16'h0c4); pkt_left = 2;

    for (int ph = 0; ph < 3; ph++) begin
      for (int n = 0; n < 2000; n++) begin
        bit v, r;
        gen_flit();
        v = ($urandom % 4) != 0;
        r = (ph == 0) ? (($urandom % 8) == 0) : (ph == 1) ? bit'($urandom % 2) : 1'b1;
        cycle(v, cur, r, a);
        if (a) begin have = 0; pkt_left--; end
      end
    end
    for (int n = 0; n < 40; n++) cycle(0, '0, 1, a);
    chk(occ == '0, "R7", "drained", occ, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule